// File: doc/BRIEF.md
# Host-Commanded Counter with Capture Tag

This block is the arithmetic core of a pulse counter that a host controls through a word of command bits. A main count register follows single-cycle count pulses, up or down. A capture strobe copies the main count into a stored-count register. Each capture also steps a small wrapping update tag. The host compares successive tag values to tell whether a fresh capture has happened between two of its reads, or whether it missed some.

The host commands are level bits. The block acts only when one of them changes from 0 to 1. One command clears the main count. One loads the main count from a host-supplied preset value. One clears the stored count. The command bits and the preset value pass through one register stage before the edge is detected. A command therefore takes effect at the second rising clock edge at which its bit reads 1.

Top module: `hc_counter_core`

## Requirements
- R1: While `rst` is 1 at a clock edge, `count_o`, `stored_o` and `tag_o` become 0 at that edge.
- R2: At an edge with `cnt_en_i`=1 and no command acting, `count_o` steps by one. It goes up when `cnt_dn_i`=0 and down when `cnt_dn_i`=1, wrapping modulo 2^CNT_W in both directions (all-ones+1 gives 0, 0-1 gives all-ones).
- R3: When `cmd_cr_i` goes from 0 to 1, `count_o` becomes 0 at the second edge that samples it high. This overrides any count pulse at that edge.
- R4: When `cmd_cp_i` goes from 0 to 1, `count_o` takes the `preset_i` value sampled at the first such edge. The load happens at the second edge, and it overrides any count pulse at that edge.
- R5: A command bit held at 1 acts once only. Further edges count normally and ignore changes of `preset_i`. A new action needs the bit to return to 0 and rise again.
- R6: If `cmd_cr_i` and `cmd_cp_i` rise in the same cycle, the clear wins and `count_o` becomes 0.
- R7: At an edge with `cap_i`=1 and no value clear acting, `stored_o` takes the `count_o` value present before that edge, and `tag_o` advances by one.
- R8: When `cmd_vr_i` goes from 0 to 1, `stored_o` becomes 0 at the second edge that samples it high. `tag_o` is unchanged.
- R9: A value clear at the same edge as a capture strobe leaves `stored_o` at 0 and `tag_o` unchanged.
- R10: `tag_o` runs 00, 01, 10, 11 and back to 00 on successive captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Count pulse, one step per cycle high |
| cnt_dn_i | input | 1 | Direction of count pulses, 1 = down |
| cap_i | input | 1 | Capture strobe |
| cmd_vr_i | input | 1 | Host bit: clear stored count on rise |
| cmd_cp_i | input | 1 | Host bit: load preset on rise |
| cmd_cr_i | input | 1 | Host bit: clear main count on rise |
| preset_i | input | CNT_W | Host preset value |
| count_o | output | CNT_W | Main count |
| stored_o | output | CNT_W | Stored count |
| tag_o | output | TAG_W | Update tag |

## Verification
The bench builds the core with CNT_W=8 and the default TAG_W=2. With that width, a single down-step from zero reaches the all-ones value. Four captures walk the tag through a complete wrap. Together these exercise both modulo boundaries within a short vector table. The 8-bit preset shows that load values travel through the sampled preset register and that a held command ignores later preset changes.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int CMD_N  = 3;
  localparam int CMD_CR = 0;   // clear main count
  localparam int CMD_CP = 1;   // load preset
  localparam int CMD_VR = 2;   // clear stored count
endpackage

// File: rtl/hc_cmd_edge.sv
module hc_cmd_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cmd_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic lvl_q, lvl_qq;
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q  <= 1'b0;
        lvl_qq <= 1'b0;
      end else begin
        lvl_q  <= cmd_i[i];
        lvl_qq <= lvl_q;
      end
    end
    assign rise_o[i] = lvl_q & ~lvl_qq;
  end
endmodule

// File: rtl/hc_main_cnt.sv
module hc_main_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  input  logic         dn_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst)          count_o <= '0;
    else if (clr_i)   count_o <= '0;
    else if (load_i)  count_o <= load_val_i;
    else if (en_i) begin
      if (dn_i) count_o <= count_o - W'(1);
      else      count_o <= count_o + W'(1);
    end
  end
endmodule

// File: rtl/hc_capture.sv
module hc_capture #(
  parameter int W     = 24,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic [W-1:0]     val_i,
  output logic [W-1:0]     stored_o,
  output logic [TAG_W-1:0] tag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stored_o <= '0;
      tag_o    <= '0;
    end else if (clr_i) begin
      stored_o <= '0;
    end else if (cap_i) begin
      stored_o <= val_i;
      tag_o    <= tag_o + TAG_W'(1);
    end
  end
endmodule

// File: rtl/hc_counter_core.sv
module hc_counter_core #(
  parameter int CNT_W = 24,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en_i,
  input  logic             cnt_dn_i,
  input  logic             cap_i,
  input  logic             cmd_vr_i,
  input  logic             cmd_cp_i,
  input  logic             cmd_cr_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] stored_o,
  output logic [TAG_W-1:0] tag_o
);
  import hc_pkg::*;

  logic [CMD_N-1:0] cmd_lvl;
  logic [CMD_N-1:0] cmd_rise;
  logic [CNT_W-1:0] preset_q;

  always_comb begin
    cmd_lvl         = '0;
    cmd_lvl[CMD_CR] = cmd_cr_i;
    cmd_lvl[CMD_CP] = cmd_cp_i;
    cmd_lvl[CMD_VR] = cmd_vr_i;
  end

  // preset sampled alongside the command bits, so it lines up with the edge
  always_ff @(posedge clk) begin
    if (rst) preset_q <= '0;
    else     preset_q <= preset_i;
  end

  hc_cmd_edge #(.N(CMD_N)) edge_i (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (cmd_lvl),
    .rise_o (cmd_rise)
  );

  hc_main_cnt #(.W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (cmd_rise[CMD_CR]),
    .load_i     (cmd_rise[CMD_CP]),
    .load_val_i (preset_q),
    .en_i       (cnt_en_i),
    .dn_i       (cnt_dn_i),
    .count_o    (count_o)
  );

  hc_capture #(.W(CNT_W), .TAG_W(TAG_W)) cap_u (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (cmd_rise[CMD_VR]),
    .cap_i    (cap_i),
    .val_i    (count_o),
    .stored_o (stored_o),
    .tag_o    (tag_o)
  );
endmodule

// File: rtl/hc_counter_core_chk.sv
module hc_counter_core_chk #(
  parameter int CNT_W = 24,
  parameter int TAG_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en_i,
  input logic             cnt_dn_i,
  input logic             cap_i,
  input logic [2:0]       rise,
  input logic [CNT_W-1:0] preset_q,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] stored_o,
  input logic [TAG_W-1:0] tag_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0 && stored_o == '0 && tag_o == '0));

  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en_i && !cnt_dn_i && rise[1:0] == 2'b00)
      |=> count_o == $past(count_o) + CNT_W'(1));

  // R3
  count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rise[0] |=> count_o == '0);

  // R4
  preset_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rise[1] && !rise[0]) |=> count_o == $past(preset_q));

  // R5
  single_action_chk: assert property (@(posedge clk) disable iff (rst)
    |rise |=> (rise & $past(rise)) == 3'b000);

  // R7
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_i && !rise[2]) |=> tag_o == $past(tag_o) + TAG_W'(1));

  // R8
  value_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rise[2] |=> (stored_o == '0 && tag_o == $past(tag_o)));
endmodule

bind hc_counter_core hc_counter_core_chk #(.CNT_W(CNT_W), .TAG_W(TAG_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cnt_en_i (cnt_en_i),
  .cnt_dn_i (cnt_dn_i),
  .cap_i    (cap_i),
  .rise     (cmd_rise),
  .preset_q (preset_q),
  .count_o  (count_o),
  .stored_o (stored_o),
  .tag_o    (tag_o)
);

// File: tb/hc_counter_core_tb_top.sv
module hc_counter_core_tb_top;
  localparam int W  = 8;
  localparam int TW = 2;
  localparam int NV = 20;

  typedef struct packed {
    logic en, dn, cap, vr, cp, cr;
    logic [W-1:0]  pre;
    logic [W-1:0]  ec;
    logic [W-1:0]  es;
    logic [TW-1:0] et;
  } vec_t;

  // expected outputs are those seen after the edge that consumes each vector
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h01, 8'h00, 2'd0}, // 0 R2 up
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h02, 8'h00, 2'd0}, // 1 R2
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h03, 8'h00, 2'd0}, // 2 R2
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'h03, 8'h03, 2'd1}, // 3 R7
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h02, 8'h03, 2'd1}, // 4 R2 down
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h03, 8'h03, 2'd1}, // 5 R3 sampled
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h00, 8'h03, 2'd1}, // 6 R3 acts
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h01, 8'h03, 2'd1}, // 7 R5 held
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h40, 8'h02, 8'h03, 2'd1}, // 8 R4 sampled
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h40, 8'h40, 8'h03, 2'd1}, // 9 R4 acts
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h99, 8'h41, 8'h03, 2'd1}, // 10 R5 held
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'h42, 8'h41, 2'd2}, // 11 R7
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h42, 8'h41, 2'd2}, // 12 R8 sampled
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 8'h00, 8'h42, 8'h00, 2'd2}, // 13 R9
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'h42, 8'h42, 2'd3}, // 14 R7
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'h42, 8'h42, 2'd0}, // 15 R10
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h10, 8'h42, 8'h42, 2'd0}, // 16 R6 sampled
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h10, 8'h00, 8'h42, 2'd0}, // 17 R6
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'hFF, 8'h42, 2'd0}, // 18 R2 wrap
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h00, 8'h42, 2'd0}  // 19 R2 wrap
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en_i = 1'b0, cnt_dn_i = 1'b0, cap_i = 1'b0;
  logic cmd_vr_i = 1'b0, cmd_cp_i = 1'b0, cmd_cr_i = 1'b0;
  logic [W-1:0]  preset_i = '0;
  logic [W-1:0]  count_o, stored_o;
  logic [TW-1:0] tag_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  hc_counter_core #(.CNT_W(W), .TAG_W(TW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .cnt_en_i (cnt_en_i),
    .cnt_dn_i (cnt_dn_i),
    .cap_i    (cap_i),
    .cmd_vr_i (cmd_vr_i),
    .cmd_cp_i (cmd_cp_i),
    .cmd_cr_i (cmd_cr_i),
    .preset_i (preset_i),
    .count_o  (count_o),
    .stored_o (stored_o),
    .tag_o    (tag_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cnt_en_i = 0; cnt_dn_i = 0; cap_i = 0;
    cmd_vr_i = 0; cmd_cp_i = 0; cmd_cr_i = 0; preset_i = '0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1", "count",  count_o,  0);
    check("R1", "stored", stored_o, 0);
    check("R1", "tag",    tag_o,    0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cnt_en_i = VEC[i].en;  cnt_dn_i = VEC[i].dn;  cap_i = VEC[i].cap;
      cmd_vr_i = VEC[i].vr;  cmd_cp_i = VEC[i].cp;  cmd_cr_i = VEC[i].cr;
      preset_i = VEC[i].pre;
      @(negedge clk);
      check($sformatf("R2-R10 vec%0d", i), "count",  count_o,  VEC[i].ec);
      check($sformatf("R7 R8 R9 vec%0d", i), "stored", stored_o, VEC[i].es);
      check($sformatf("R7 R10 vec%0d", i), "tag",    tag_o,    VEC[i].et);
    end

    // R8: lone value clear keeps tag; capture first to get a nonzero stored value
    idle_inputs();
    cap_i = 1; @(negedge clk);          // stored=0x00, tag=1
    cap_i = 0; cnt_en_i = 1; @(negedge clk); // count 0x01
    cap_i = 1; cnt_en_i = 0; @(negedge clk); // stored=0x01, tag=2
    check("R7", "stored", stored_o, 8'h01);
    check("R7", "tag",    tag_o,    2);
    cap_i = 0; cmd_vr_i = 1; @(negedge clk);
    @(negedge clk);
    check("R8", "stored", stored_o, 0);
    check("R8", "tag",    tag_o,    2);
    cmd_vr_i = 1; @(negedge clk);       // held: nothing more
    check("R5", "tag", tag_o, 2);

    // R1: reset after activity
    idle_inputs();
    rst = 1; @(negedge clk);
    check("R1", "count",  count_o,  0);
    check("R1", "stored", stored_o, 0);
    check("R1", "tag",    tag_o,    0);
    rst = 0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule